// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with HI/LO Result Pair

This block is the integer multiply and divide engine that sits beside the execute stage of a small 32-bit RISC pipeline. A request carries a 3-bit operation code and two source operands, `rs` and `rt`. Multiply and divide share one pair of result registers, HI and LO. A multiply leaves the full double-length product across the pair. A divide leaves the quotient in LO and the remainder in HI. Separate operations copy a source operand into HI or LO, and others read either register back.

Multiply uses a shift-and-add loop and divide uses a restoring loop. Each takes one step per clock for 32 steps. While an operation runs, `busy` is high and further requests are dropped. A one-cycle `done` pulse marks the cycle in which the new HI/LO contents appear. A read of HI or LO that arrives during an operation is held off with `ready` low. Two sticky status flags report on the last completed operation. One tells whether the product would overflow a single word, which the pipeline needs for overflow-trapping multiplies. The other reports a zero divisor.

Top module: `muldiv_hilo`

## Requirements
- R1: Operation codes are 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 read HI, 5 read LO, 6 write HI, 7 write LO. A signed multiply puts bits 63:32 of the two's-complement product of `rs` and `rt` in HI and bits 31:0 in LO.
- R2: An unsigned multiply treats both operands as unsigned and places the 64-bit product in HI (upper) and LO (lower).
- R3: On completion of a multiply, `ovf` is set when the product is outside the 32-bit range: -2^31..2^31-1 for signed, 0..2^32-1 for unsigned. On completion of a divide, `ovf` is cleared. `ovf` holds its value until the next completion.
- R4: A signed divide truncates the quotient toward zero and writes it to LO. The remainder, written to HI, has the sign of the dividend. -2^31 divided by -1 gives quotient 0x80000000 and remainder 0, and does not set `dbz`.
- R5: An unsigned divide writes `rs / rt` to LO and `rs % rt` to HI.
- R6: A divide with `rt` = 0 still completes on schedule with LO = 0xFFFFFFFF and HI = `rs`, and sets `dbz`. Any other completion clears `dbz`.
- R7: When idle, a write-HI or write-LO request loads `rs` into that register at the next edge and leaves the other register unchanged. `rdata` shows HI for op 4 and LO for op 5 whenever `ready` is high.
- R8: An accepted multiply or divide raises `busy` at the next edge. `done` pulses for exactly one cycle, 32 cycles after acceptance. In that same cycle `busy` is low and HI/LO already hold the result.
- R9: While `busy` is high, `ready` is low, and every request, including a write to HI/LO or a new arithmetic start, is ignored.
- R10: After reset, HI and LO are 0 and `busy`, `done`, `ovf` and `dbz` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request valid for arithmetic or write operations |
| op | input | 3 | Operation code (see R1); also selects the `rdata` source |
| rs | input | 32 | First operand / dividend / value to write |
| rt | input | 32 | Second operand / divisor |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle pulse when HI/LO receive a new result |
| ready | output | 1 | Reads and new requests may proceed |
| rdata | output | 32 | HI (op 4) or LO (op 5) |
| ovf | output | 1 | Last product does not fit in one word |
| dbz | output | 1 | Last divide had a zero divisor |

## Verification
Each arithmetic operation is run on seeded random operands and on directed extremes. The extremes include 0, ±1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and these pairs show whether the signed and unsigned paths actually apply different sign handling to the same bit patterns. Products just inside and just outside the one-word range separate the signed overflow rule from the unsigned one. Signed divides with mixed operand signs fix the truncation direction and the sign of the remainder, and -2^31/-1 and zero divisors exercise the special completions. Requests issued while an operation runs show that they neither restart it nor change HI/LO, and the cycle count to `done` confirms the fixed latency.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] rs,
  input  logic [W-1:0] rt,
  output logic         busy,
  output logic         done,
  output logic         ready,
  output logic [W-1:0] rdata,
  output logic         ovf,
  output logic         dbz
);
  localparam int CW = $clog2(W);
  localparam int PW = 2 * W + 1;

  logic [W-1:0]  hi, lo, m;
  logic [PW-1:0] p;
  logic [CW-1:0] cnt;
  logic          is_div, is_sgn, negq, negr, dz;

  wire          sgn = ~op[0];
  wire [W-1:0]  ua  = (sgn && rs[W-1]) ? -rs : rs;
  wire [W-1:0]  ub  = (sgn && rt[W-1]) ? -rt : rt;
  wire          last = (cnt == CW'(W - 1));

  // multiply step: conditional add into upper half, shift right
  wire [W:0]     msum = p[PW-1:W] + {1'b0, (p[0] ? m : {W{1'b0}})};
  wire [2*W-1:0] pmul = {msum, p[W-1:1]};

  // restoring divide step: shift in next dividend bit, try subtract
  wire [W:0]   t    = {p[2*W-1:W], p[W-1]};
  wire [W:0]   diff = t - {1'b0, m};
  wire         ge   = t[W] | ~diff[W];
  wire [W-1:0] tr   = ge ? diff[W-1:0] : t[W-1:0];
  wire [PW-1:0] pdiv = {1'b0, tr, p[W-2:0], ge};

  wire [2*W-1:0] prod = negq ? -pmul : pmul;
  wire [W-1:0]   quo  = dz ? {W{1'b1}} : (negq ? -pdiv[W-1:0] : pdiv[W-1:0]);
  wire [W-1:0]   rem  = negr ? -tr : tr;
  wire [W-1:0]   res_hi = is_div ? rem : prod[2*W-1:W];
  wire [W-1:0]   res_lo = is_div ? quo : prod[W-1:0];
  wire           ov = !is_div &&
                      (is_sgn ? (res_hi != {W{res_lo[W-1]}}) : (res_hi != '0));

  assign ready = ~busy;
  assign rdata = op[0] ? lo : hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi <= '0; lo <= '0; m <= '0; p <= '0; cnt <= '0;
      busy <= 1'b0; done <= 1'b0; ovf <= 1'b0; dbz <= 1'b0;
      is_div <= 1'b0; is_sgn <= 1'b0; negq <= 1'b0; negr <= 1'b0; dz <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        p   <= is_div ? pdiv : {1'b0, pmul};
        cnt <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          hi   <= res_hi;
          lo   <= res_lo;
          ovf  <= ov;
          dbz  <= is_div && dz;
        end
      end else if (start) begin
        if (!op[2]) begin
          busy   <= 1'b1;
          cnt    <= '0;
          p      <= {{(W + 1){1'b0}}, ua};
          m      <= ub;
          is_div <= op[1];
          is_sgn <= sgn;
          negq   <= sgn && (rs[W-1] ^ rt[W-1]);
          negr   <= sgn && rs[W-1];
          dz     <= (rt == '0);
        end else if (op == 3'd6) begin
          hi <= rs;
        end else if (op == 3'd7) begin
          lo <= rs;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [2:0]   op,
  input logic         busy,
  input logic         done,
  input logic         ovf,
  input logic         dbz,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  // R8: done never overlaps busy
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: done only directly after a busy cycle, and lasts one cycle
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: accepted arithmetic start raises busy
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[2]) |=> busy);

  // R9 / R7: HI/LO only change on completion or an idle write
  assert_hilo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && op[2] && op[1])) |=> ($stable(hi) && $stable(lo)));

  // R3 / R6: flags change only on completion and are never both set
  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && dbz));
  assert_ovf_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovf) |-> done);
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .busy(busy),
  .done(done), .ovf(ovf), .dbz(dbz), .hi(hi), .lo(lo)
);

// File: tb/muldiv_hilo_test.sv
`timescale 1ns/1ps
module muldiv_hilo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd4;
  logic [31:0] rs = '0, rt = '0;
  logic        busy, done, ready, ovf, dbz;
  logic [31:0] rdata;
  int          tests = 0, fails = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  muldiv_hilo uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rs(rs), .rt(rt),
    .busy(busy), .done(done), .ready(ready), .rdata(rdata), .ovf(ovf), .dbz(dbz)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns {ovf, dbz, hi, lo}
  function automatic logic [65:0] model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, sp, q, r;
    logic [63:0] up;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      3'd0: begin
        sp = sa * sb;
        return {(sp > 64'sd2147483647) || (sp < -64'sd2147483648), 1'b0, sp[63:0]};
      end
      3'd1: begin
        up = {32'd0, a} * {32'd0, b};
        return {up[63:32] != 0, 1'b0, up};
      end
      3'd2: begin
        if (b == 0) return {2'b01, a, 32'hFFFF_FFFF};
        q = sa / sb;
        r = sa % sb;
        return {2'b00, r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {2'b01, a, 32'hFFFF_FFFF};
        return {2'b00, a % b, a / b};
      end
    endcase
  endfunction

  function automatic string tag(input logic [2:0] o, input logic [31:0] b);
    if (o >= 3'd2 && b == 0) return "R6";
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic read_hilo(output logic [31:0] h, output logic [31:0] l);
    op = 3'd4; #1 h = rdata;
    op = 3'd5; #1 l = rdata;
  endtask

  task automatic run(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [65:0] e;
    logic [31:0] h, l;
    int cyc;
    e = model(o, a, b);
    @(negedge clk);
    start = 1'b1; op = o; rs = a; rt = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
    chk("R8 latency", 64'(cyc), 64'd32);
    chk("R8 busy low at done", {63'd0, busy}, 64'd0);
    read_hilo(h, l);
    chk({tag(o, b), " hi"}, {32'd0, h}, {32'd0, e[63:32]});
    chk({tag(o, b), " lo"}, {32'd0, l}, {32'd0, e[31:0]});
    chk("R3 ovf", {63'd0, ovf}, {63'd0, e[65]});
    chk("R6 dbz", {63'd0, dbz}, {63'd0, e[64]});
  endtask

  task automatic write(input logic [2:0] o, input logic [31:0] v);
    @(negedge clk);
    start = 1'b1; op = o; rs = v;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] h, l, a, b, v;
    logic [2:0]  o;
    v = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    read_hilo(h, l);
    chk("R10 hi", {32'd0, h}, 64'd0);
    chk("R10 lo", {32'd0, l}, 64'd0);
    chk("R10 flags", {60'd0, busy, done, ovf, dbz}, 64'd0);
    rst_n = 1'b1;

    // R7 idle writes and reads
    write(3'd6, 32'hDEAD_BEEF);
    write(3'd7, 32'h1234_5678);
    read_hilo(h, l);
    chk("R7 hi write", {32'd0, h}, {32'd0, 32'hDEAD_BEEF});
    chk("R7 lo write", {32'd0, l}, {32'd0, 32'h1234_5678});
    write(3'd7, 32'h0BAD_F00D);
    read_hilo(h, l);
    chk("R7 hi untouched", {32'd0, h}, {32'd0, 32'hDEAD_BEEF});

    // directed corners
    run(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run(3'd0, 32'h8000_0000, 32'h8000_0000);
    run(3'd1, 32'h8000_0000, 32'h0000_0002);
    run(3'd0, 32'h0000_FFFF, 32'h0000_8000);
    run(3'd0, 32'h0001_0000, 32'h0000_8000);
    run(3'd0, 32'hFFFF_0000, 32'h0000_8000);
    run(3'd0, 32'h7FFF_FFFF, 32'h0000_0001);
    run(3'd1, 32'h0001_0000, 32'h0001_0000);
    run(3'd2, 32'hFFFF_FFF9, 32'h0000_0002);
    run(3'd2, 32'h0000_0007, 32'hFFFF_FFFE);
    run(3'd2, 32'h8000_0000, 32'hFFFF_FFFF);
    run(3'd3, 32'hFFFF_FFF9, 32'h0000_0002);
    run(3'd2, 32'h8000_0001, 32'h0000_0000);
    run(3'd3, 32'hCAFE_0001, 32'h0000_0000);
    run(3'd3, 32'h0000_0005, 32'h0000_0007);

    // R9: requests while busy are ignored and reads are held off
    @(negedge clk);
    start = 1'b1; op = 3'd0; rs = 32'd300; rt = 32'hFFFF_FFFD;
    @(negedge clk);
    op = 3'd6; rs = 32'h5555_5555;
    @(negedge clk);
    op = 3'd1; rs = 32'd9; rt = 32'd9;
    @(negedge clk);
    op = 3'd7; rs = 32'hAAAA_AAAA;
    @(negedge clk);
    chk("R9 ready low while busy", {62'd0, ready, busy}, 64'd1);
    start = 1'b0;
    while (!done) @(negedge clk);
    read_hilo(h, l);
    chk("R9 hi not overwritten", {32'd0, h}, {32'd0, 32'hFFFF_FFFF});
    chk("R9 lo not overwritten", {32'd0, l}, {32'd0, 32'hFFFF_FC7C});
    @(negedge clk);
    chk("R8 done single cycle", {62'd0, done, ready}, 64'd1);

    // random mix
    for (int i = 0; i < 60; i++) begin
      o = 3'($urandom % 4);
      a = $urandom;
      b = $urandom;
      if (i % 5 == 0) b = b >> ($urandom % 32);
      if (i % 7 == 0) a = a >> ($urandom % 32);
      run(o, a, b);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule